// File: doc/BRIEF.md
# Strip Cluster Centroid Encoder

The block reads a 120-channel binary hit image from a silicon strip sensor once per bunch-crossing clock. Runs of neighbouring hit strips are merged into clusters. Each cluster is reduced to a centroid in half-strip units, shifted by a signed geometric parallax offset, clamped to the sensor range and placed in a short list of centroid words, lowest strip first.

Clusters wider than a programmable strip count are rejected as noise or track debris. No more than eight centroids leave per crossing, and a flag marks crossings that had more accepted clusters than that. The pipeline has three register stages and takes a new image on every clock, so the list for a crossing appears exactly three clocks after the image, with its own valid flag.

The cluster-width limit and the parallax offset are sampled together with each hit image and travel down the pipeline with it. A setting change therefore applies cleanly from one crossing to the next.

Top module: `strip_centroid_enc`

## Requirements
- R1: While rst_ni is low, and after it, until the first valid crossing has passed through the pipeline, valid_o, overflow_o, cent_cnt_o and cent_o are all zero.
- R2: valid_o equals hits_valid_i from exactly three rising clock edges earlier, and a new crossing is accepted on every clock with no stall.
- R3: A cluster is a maximal run of adjacent hit strips (bit n of hits_i is strip n). Its centroid is first strip plus last strip, an 8-bit value in half-strip units.
- R4: A cluster whose strip count exceeds max_width_i (0 to 15) is discarded. A cluster of exactly max_width_i strips is kept, and max_width_i = 0 discards every cluster.
- R5: Accepted centroids are reported in ascending strip order, slot k in cent_o[8k+7:8k]. There are at most 8 of them, and cent_cnt_o gives how many slots are filled.
- R6: overflow_o is 1 exactly when more than 8 clusters were accepted in that crossing. Clusters discarded for width do not count.
- R7: parallax_i is a 4-bit two's-complement offset added to every reported centroid. The result is clamped to the range 0 to 239.
- R8: A cluster that includes strip 0 or strip 119 ends at the array edge and is reported like any other cluster.
- R9: Slots at or above cent_cnt_o are zero. A crossing with hits_valid_i low yields valid_o low, zero count, zero overflow and zero slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hits_i | input | 120 | Binary hit per strip, bit n = strip n |
| hits_valid_i | input | 1 | hits_i holds a crossing this clock |
| max_width_i | input | 4 | Largest accepted cluster width in strips |
| parallax_i | input | 4 | Signed parallax offset in half-strip units |
| cent_o | output | 64 | Eight centroid slots, slot k at bits 8k+7:8k |
| cent_cnt_o | output | 4 | Number of filled slots, 0 to 8 |
| overflow_o | output | 1 | More than 8 clusters accepted this crossing |
| valid_o | output | 1 | Outputs carry the crossing from three clocks earlier |

## Verification
A run-length register that saturates wrongly, or a lost edge guard, shows up as a shifted centroid or a missing or extra slot. This appears in the list for the same crossing, three clocks after the image. An ordering or count fault in the selector shows as slots out of order, non-zero slots above the count, or an overflow flag without a full list, and the checker catches these on every valid cycle. A misaligned configuration stage shows as an offset or width limit landing one crossing early or late. Back-to-back vectors with changing settings expose this on the next output cycle.

// File: rtl/strip_centroid_pkg.sv
package strip_centroid_pkg;
  localparam int N_STRIPS = 120;
  localparam int POS_W    = 8;
  localparam int MAX_CL   = 8;
  localparam int W_LIM    = 15;
  localparam int PAR_W    = 4;
  localparam int WID_W    = $clog2(W_LIM + 1);
  localparam int CNT_W    = $clog2(MAX_CL + 1);
  localparam int POS_MAX  = 2 * N_STRIPS - 1;
endpackage

// File: rtl/cluster_detect.sv
module cluster_detect import strip_centroid_pkg::*; #(
  parameter int N     = N_STRIPS,
  parameter int WLIM  = W_LIM,
  parameter int WW    = WID_W,
  parameter int PW    = POS_W
) (
  input  logic [N-1:0]  hits_i,
  input  logic [WW-1:0] max_width_i,
  output logic [N-1:0]  keep_o,
  output logic [PW-1:0] cent_o [N]
);
  localparam int LEN_W = $clog2(WLIM + 2);

  for (genvar i = 0; i < N; i++) begin : g_strip
    localparam int JMAX = (i < WLIM) ? i : WLIM;
    logic             is_end;
    logic [LEN_W-1:0] len;
    logic             run;

    if (i == N - 1) begin : g_last
      assign is_end = hits_i[i];
    end else begin : g_mid
      assign is_end = hits_i[i] & ~hits_i[i+1];
    end

    // run length ending at i, saturating at WLIM+1 (too wide)
    always_comb begin
      len = '0;
      run = 1'b1;
      for (int j = 0; j <= JMAX; j++) begin
        if (run && hits_i[i-j]) len = len + LEN_W'(1);
        else                    run = 1'b0;
      end
    end

    assign keep_o[i] = is_end && (len <= LEN_W'(max_width_i));
    assign cent_o[i] = keep_o[i] ? (PW'(2 * i + 1) - PW'(len)) : '0;
  end
endmodule

// File: rtl/centroid_select.sv
module centroid_select import strip_centroid_pkg::*; #(
  parameter int N  = N_STRIPS,
  parameter int MC = MAX_CL,
  parameter int PW = POS_W,
  parameter int CW = CNT_W
) (
  input  logic [N-1:0]  keep_i,
  input  logic [PW-1:0] cent_i [N],
  output logic [PW-1:0] slot_o [MC],
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam int TOT_W = $clog2(N + 1);
  logic [TOT_W-1:0] tot;

  always_comb begin
    tot = '0;
    for (int k = 0; k < MC; k++) slot_o[k] = '0;
    for (int i = 0; i < N; i++) begin
      if (keep_i[i]) begin
        for (int k = 0; k < MC; k++)
          if (tot == TOT_W'(k)) slot_o[k] = cent_i[i];
        tot = tot + TOT_W'(1);
      end
    end
    ovf_o = tot > TOT_W'(MC);
    cnt_o = ovf_o ? CW'(MC) : CW'(tot);
  end
endmodule

// File: rtl/parallax_adj.sv
module parallax_adj import strip_centroid_pkg::*; #(
  parameter int PW   = POS_W,
  parameter int AW   = PAR_W,
  parameter int PMAX = POS_MAX
) (
  input  logic [PW-1:0] pos_i,
  input  logic [AW-1:0] off_i,
  output logic [PW-1:0] pos_o
);
  localparam int SW = PW + 2;
  logic [SW-1:0] sum;

  assign sum = {2'b00, pos_i} + {{(SW - AW){off_i[AW-1]}}, off_i};

  always_comb begin
    if (sum[SW-1])                pos_o = '0;
    else if (sum > SW'(PMAX))     pos_o = PW'(PMAX);
    else                          pos_o = sum[PW-1:0];
  end
endmodule

// File: rtl/strip_centroid_enc.sv
module strip_centroid_enc import strip_centroid_pkg::*; #(
  parameter int N    = N_STRIPS,
  parameter int PW   = POS_W,
  parameter int MC   = MAX_CL,
  parameter int WLIM = W_LIM,
  parameter int AW   = PAR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         hits_i,
  input  logic                 hits_valid_i,
  input  logic [$clog2(WLIM+1)-1:0] max_width_i,
  input  logic [AW-1:0]        parallax_i,
  output logic [MC*PW-1:0]     cent_o,
  output logic [$clog2(MC+1)-1:0] cent_cnt_o,
  output logic                 overflow_o,
  output logic                 valid_o
);
  localparam int WW   = $clog2(WLIM + 1);
  localparam int CW   = $clog2(MC + 1);
  localparam int PMAX = 2 * N - 1;

  // stage 1: capture crossing and its settings
  logic [N-1:0]  hits_q;
  logic [WW-1:0] maxw_q;
  logic [AW-1:0] par_q, par_q2;
  logic          vld_q, vld_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q <= '0;
      maxw_q <= '0;
      par_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      hits_q <= hits_valid_i ? hits_i : '0;
      maxw_q <= max_width_i;
      par_q  <= parallax_i;
      vld_q  <= hits_valid_i;
    end
  end

  // stage 2: cluster ends and centroids per strip
  logic [N-1:0]  keep_d, keep_q;
  logic [PW-1:0] cent_d [N];
  logic [PW-1:0] cent_q [N];

  cluster_detect #(.N(N), .WLIM(WLIM), .WW(WW), .PW(PW)) u_detect (
    .hits_i      (hits_q),
    .max_width_i (maxw_q),
    .keep_o      (keep_d),
    .cent_o      (cent_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= '0;
      for (int i = 0; i < N; i++) cent_q[i] <= '0;
      par_q2 <= '0;
      vld_q2 <= 1'b0;
    end else begin
      keep_q <= keep_d;
      for (int i = 0; i < N; i++) cent_q[i] <= cent_d[i];
      par_q2 <= par_q;
      vld_q2 <= vld_q;
    end
  end

  // stage 3: pick first MC, apply parallax, register out
  logic [PW-1:0] slot [MC];
  logic [PW-1:0] adj  [MC];
  logic [CW-1:0] sel_cnt;
  logic          sel_ovf;

  centroid_select #(.N(N), .MC(MC), .PW(PW), .CW(CW)) u_select (
    .keep_i (keep_q),
    .cent_i (cent_q),
    .slot_o (slot),
    .cnt_o  (sel_cnt),
    .ovf_o  (sel_ovf)
  );

  for (genvar k = 0; k < MC; k++) begin : g_adj
    parallax_adj #(.PW(PW), .AW(AW), .PMAX(PMAX)) u_adj (
      .pos_i (slot[k]),
      .off_i (par_q2),
      .pos_o (adj[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cent_o     <= '0;
      cent_cnt_o <= '0;
      overflow_o <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      for (int k = 0; k < MC; k++)
        cent_o[k*PW +: PW] <= (CW'(k) < sel_cnt) ? adj[k] : '0;
      cent_cnt_o <= sel_cnt;
      overflow_o <= sel_ovf;
      valid_o    <= vld_q2;
    end
  end
endmodule

// File: rtl/strip_centroid_chk.sv
module strip_centroid_chk #(
  parameter int PW   = 8,
  parameter int MC   = 8,
  parameter int PMAX = 239
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    hits_valid_i,
  input logic [MC*PW-1:0]        cent_o,
  input logic [$clog2(MC+1)-1:0] cent_cnt_o,
  input logic                    overflow_o,
  input logic                    valid_o
);
  localparam int CW = $clog2(MC + 1);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(hits_valid_i, 3)));

  p_cnt_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cent_cnt_o <= CW'(MC));

  p_ovf_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (cent_cnt_o == CW'(MC)));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cent_cnt_o == '0 && !overflow_o && cent_o == '0));

  for (genvar k = 0; k < MC; k++) begin : g_slot
    p_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cent_o[k*PW +: PW] <= PW'(PMAX));
    p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CW'(k) >= cent_cnt_o) |-> (cent_o[k*PW +: PW] == '0));
    if (k > 0) begin : g_ord
      p_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (CW'(k) < cent_cnt_o) |-> (cent_o[k*PW +: PW] >= cent_o[(k-1)*PW +: PW]));
    end
  end
endmodule

bind strip_centroid_enc strip_centroid_chk #(.PW(PW), .MC(MC), .PMAX(PMAX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hits_valid_i (hits_valid_i),
  .cent_o       (cent_o),
  .cent_cnt_o   (cent_cnt_o),
  .overflow_o   (overflow_o),
  .valid_o      (valid_o)
);

// File: tb/sim_strip_centroid_enc.sv
module sim_strip_centroid_enc;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [119:0] hits;
    logic [3:0]   maxw;
    logic [3:0]   par;
    logic [3:0]   cnt;
    logic         ovf;
    logic [63:0]  cents;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{(120'd1 << 5), 4'd4, 4'h0, 4'd1, 1'b0, 64'h0a},                          // R3 single
    '{(120'h7 << 10) | (120'h3 << 20), 4'd4, 4'h0, 4'd2, 1'b0, 64'h29_16},     // R3 R5
    '{(120'hf << 30) | (120'h1f << 40) | (120'd1 << 50), 4'd4, 4'h0, 4'd2, 1'b0, 64'h64_3f}, // R4
    '{(120'h7 << 10) | (120'h3 << 20), 4'd2, 4'h0, 4'd1, 1'b0, 64'h29},        // R4 limit 2
    '{120'h3 | (120'h3 << 118), 4'd4, 4'h0, 4'd2, 1'b0, 64'hed_01},            // R8 edges
    '{120'h55555, 4'd4, 4'h0, 4'd8, 1'b1, 64'h1c18_1410_0c08_0400},            // R6 overflow
    '{120'h5555, 4'd4, 4'h0, 4'd8, 1'b0, 64'h1c18_1410_0c08_0400},             // R5 exactly 8
    '{(120'd1 << 3), 4'd4, 4'h5, 4'd1, 1'b0, 64'h0b},                          // R7 +5
    '{120'h1 | (120'd1 << 119), 4'd4, 4'hd, 4'd2, 1'b0, 64'heb_00},            // R7 -3 clamp low
    '{(120'd1 << 1) | (120'd1 << 119), 4'd4, 4'h7, 4'd2, 1'b0, 64'hef_09},     // R7 clamp high
    '{120'h3f | (120'h5555 << 10), 4'd4, 4'h0, 4'd8, 1'b0, 64'h302c_2824_201c_1814}, // R6 wide not counted
    '{(120'd1 << 5), 4'd0, 4'h0, 4'd0, 1'b0, 64'h0},                           // R4 limit 0
    '{{120{1'b1}}, 4'd15, 4'h0, 4'd0, 1'b0, 64'h0},                            // R4 R8 full array too wide
    '{120'h7fff, 4'd15, 4'h0, 4'd1, 1'b0, 64'h0e}                              // R4 width 15 kept
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [119:0] hits = '0;
  logic         hv = 1'b0;
  logic [3:0]   maxw = 4'd4;
  logic [3:0]   par = '0;
  logic [63:0]  cent;
  logic [3:0]   cnt;
  logic         ovf;
  logic         vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strip_centroid_enc u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .hits_i       (hits),
    .hits_valid_i (hv),
    .max_width_i  (maxw),
    .parallax_i   (par),
    .cent_o       (cent),
    .cent_cnt_o   (cnt),
    .overflow_o   (ovf),
    .valid_o      (vld)
  );

  task automatic check(input bit ok, input string what, input logic [69:0] act, input logic [69:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic check_out(input string what, input logic e_v, input logic [3:0] e_c,
                           input logic e_o, input logic [63:0] e_cent);
    logic [69:0] a, e;
    a = {vld, cnt, ovf, cent};
    e = {e_v, e_c, e_o, e_cent};
    check(a === e, what, a, e);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1 outputs zero in reset", 1'b0, 4'd0, 1'b0, 64'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_out("R1 outputs zero after reset", 1'b0, 4'd0, 1'b0, 64'h0);

    // R2 streamed table, one crossing per clock
    for (int i = 0; i < NV + 3; i++) begin
      if (i >= 3)
        check_out($sformatf("R2 table entry %0d", i - 3), 1'b1, TBL[i-3].cnt,
                  TBL[i-3].ovf, TBL[i-3].cents);
      if (i < NV) begin
        hits = TBL[i].hits; maxw = TBL[i].maxw; par = TBL[i].par; hv = 1'b1;
      end else begin
        hits = '0; hv = 1'b0; maxw = 4'd4; par = '0;
      end
      @(negedge clk);
    end

    // R9 hits present but not valid
    hits = {120{1'b1}} ^ (120'd1 << 60); par = 4'h7; hv = 1'b0;
    repeat (4) @(negedge clk);
    check_out("R9 invalid crossing idle", 1'b0, 4'd0, 1'b0, 64'h0);

    // R2 single pulse latency
    hits = (120'd1 << 7); par = '0; maxw = 4'd4; hv = 1'b1;
    @(negedge clk);
    hv = 1'b0; hits = '0;
    @(negedge clk);
    check_out("R2 not yet valid at 2 clocks", 1'b0, 4'd0, 1'b0, 64'h0);
    @(negedge clk);
    check_out("R2 valid at 3 clocks", 1'b1, 4'd1, 1'b0, 64'h0e);
    @(negedge clk);
    check_out("R9 back to idle", 1'b0, 4'd0, 1'b0, 64'h0);

    // R8 cluster at strip 119 only, with 3 wide ending at edge
    hits = (120'h7 << 117); hv = 1'b1;
    @(negedge clk);
    hv = 1'b0; hits = '0;
    repeat (2) @(negedge clk);
    check_out("R8 upper edge cluster", 1'b1, 4'd1, 1'b0, 64'hec);

    // R1 reset while data in flight
    hits = (120'd1 << 9); hv = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b0; hv = 1'b0;
    #1;
    check_out("R1 reset clears in-flight data", 1'b0, 4'd0, 1'b0, 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R1 nothing emerges after reset", 1'b0, 4'd0, 1'b0, 64'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule